// File: doc/BRIEF.md
# Mode-Switchable Direct-Mapped Cache

This block is a 2-Kbyte direct-mapped cache. It sits between a processor core and one local bus that carries both instruction and data traffic. A two-bit mode input selects one of three roles for the same storage. It can serve as an instruction cache, as a write-through data cache, or as a split cache in which one half of the lines holds instructions and the other half holds data. The storage has 128 lines of four 32-bit words. Each line has an address tag and a valid bit.

The core presents one request and holds it until the cache answers. A read that hits is answered in the same cycle from the word array, with no bus activity. A read miss on a cacheable access fetches the whole line as four single-word bus reads. The beats go into the line-fill buffer for the requesting side, and the requested word is passed to the core in the cycle its beat arrives. The line is installed when the last beat lands. Writes always go to the bus. A write that hits also updates the cached word, and a write that misses allocates nothing. Accesses of the type that the current mode does not cache use a single uncached bus transfer. An invalidate input clears every valid bit, and it must be used before each change of mode.

Top module: `cfgSplitCache`

## Requirements
- R1: After reset no line is valid, busReq and respValid are low, and the first read of any cacheable address misses.
- R2: Mode encoding is 2'b00 instruction-only, 2'b01 data-only, 2'b10 or 2'b11 split. In a single-type mode, a read of the other type is a single-word bus read at reqAddr that allocates nothing, so repeating it misses again.
- R3: Single-type modes use reqAddr[10:4] as line index. Split mode uses {reqIsInstr, reqAddr[9:4]} as line index. reqAddr[3:2] selects the word. The tag compared is reqAddr[31:10], so two addresses with the same index and different tags evict each other.
- R4: A read hit raises respValid with the stored word in the same cycle as the request, with busReq low.
- R5: A read miss issues exactly four bus reads at the line base plus 0, 4, 8 and 12, in that order. busReq, busAddr and busWrite stay stable until busAck.
- R6: During a refill, respValid rises with busRdata in the cycle that the requested word's beat is acknowledged. After the fourth beat the line is valid, and reads of any of its words hit.
- R7: A write drives one bus write of reqAddr and reqWdata and answers on busAck. A write hit also updates the cached word. A write miss leaves the cache unchanged.
- R8: Only one bus operation is in progress at a time. A request made while a refill continues after its forwarded word gets no respValid until that refill has finished.
- R9: invAll clears all valid bits at the next clock edge. A refill that sees invAll in any cycle while it fetches beats, including the cycle of its last beat, does not install its line.
- R10: In split mode, an instruction line and a data line with the same address coexist and both hit.
- R11: A read hit in the same cycle as invAll is still answered with the stored word, and the next read of that address misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 instruction-only, 01 data-only, 1x split |
| invAll | input | 1 | Clear all valid bits |
| reqValid | input | 1 | Core request present, held until respValid |
| reqIsInstr | input | 1 | 1 for instruction fetch, 0 for operand access |
| reqWrite | input | 1 | 1 for write |
| reqAddr | input | 32 | Word-aligned request address |
| reqWdata | input | 32 | Write data |
| respValid | output | 1 | Request answered this cycle |
| respData | output | 32 | Read data when respValid |
| busReq | output | 1 | Bus transfer requested |
| busWrite | output | 1 | Bus transfer is a write |
| busAddr | output | 32 | Bus word address |
| busWdata | output | 32 | Bus write data |
| busAck | input | 1 | Bus transfer completes this cycle |
| busRdata | input | 32 | Bus read data when busAck |

## Verification
Invalidation can land in the same cycle as a line install, and also in the same cycle as a read hit. The bench raises invAll two cycles into a refill, and separately together with a read of a resident line. It then checks that the refilled line misses, that the coincident hit still returns its word, and that the next access to that line goes to the bus. A reference model applies the same priority rule. It is compared against the ports on every cycle, while a bus responder with irregular gaps between acknowledges stretches each refill.

// File: rtl/cfgsc_pkg.sv
package cfgsc_pkg;
  localparam int LINE_WORDS = 4;
  localparam int BEAT_W = $clog2(LINE_WORDS);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SINGLE} ctlState_t;

  typedef struct packed {
    logic              startMiss;
    logic              fillBeat;
    logic              lineWrite;
    logic              wordWrite;
    logic              inFill;
    logic [BEAT_W-1:0] beat;
  } ctlStrobe_t;
endpackage

// File: rtl/cfgscDatapath.sv
module cfgscDatapath
  import cfgsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              invAll,
  input  logic              reqIsInstr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       busRdata,
  input  ctlStrobe_t        ctl,
  output logic              hit,
  output logic              cacheable,
  output logic [31:0]       rdWord,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic [BEAT_W-1:0] reqWordOff,
  output logic [LINES-1:0]  validView
);
  localparam int IDX_W   = $clog2(LINES);
  localparam int OFF_W   = BEAT_W + 2;
  localparam int TAG_LSB = IDX_W + OFF_W - 1;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int WORDS   = LINES * LINE_WORDS;

  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [31:0]       dataMem [WORDS];
  logic [LINES-1:0]  valid;

  logic              split;
  logic [IDX_W-1:0]  curIdx;
  logic [ADDR_W-1:0] lAddr;
  logic [31:0]       lWdata;
  logic [IDX_W-1:0]  lIdx;
  logic              lInstr;
  logic              lHit;
  logic [31:0]       lineWords [LINE_WORDS];

  function automatic logic [IDX_W-1:0] lineIndex(input logic [ADDR_W-1:0] a,
                                                 input logic instr,
                                                 input logic splitMode);
    logic [IDX_W-1:0] r;
    r = a[IDX_W+OFF_W-1:OFF_W];
    if (splitMode) r[IDX_W-1] = instr;
    return r;
  endfunction

  assign split     = mode[1];
  assign cacheable = split | (mode[0] ? !reqIsInstr : reqIsInstr);
  assign curIdx    = lineIndex(reqAddr, reqIsInstr, split);
  assign hit       = cacheable && valid[curIdx] &&
                     (tagMem[curIdx] == reqAddr[ADDR_W-1:TAG_LSB]);
  assign rdWord    = dataMem[{curIdx, reqAddr[OFF_W-1:2]}];

  // Miss context captured once, so the core may drop its request after forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lAddr  <= '0;
      lWdata <= '0;
      lIdx   <= '0;
      lInstr <= 1'b0;
      lHit   <= 1'b0;
    end else if (ctl.startMiss) begin
      lAddr  <= reqAddr;
      lWdata <= reqWdata;
      lIdx   <= curIdx;
      lInstr <= reqIsInstr;
      lHit   <= hit;
    end
  end

  // One line-fill buffer per side: index 1 instruction, index 0 data
  for (genvar s = 0; s < 2; s++) begin : g_fillBuf
    logic [31:0] words [LINE_WORDS];
    always_ff @(posedge clk) begin
      if (ctl.fillBeat && (lInstr == 1'(s))) words[ctl.beat] <= busRdata;
    end
  end

  always_comb begin
    for (int w = 0; w < LINE_WORDS; w++)
      lineWords[w] = lInstr ? g_fillBuf[1].words[w] : g_fillBuf[0].words[w];
  end

  always_ff @(posedge clk) begin
    if (ctl.lineWrite) begin
      tagMem[lIdx] <= lAddr[ADDR_W-1:TAG_LSB];
      for (int w = 0; w < LINE_WORDS; w++)
        dataMem[{lIdx, BEAT_W'(w)}] <= (w == LINE_WORDS - 1) ? busRdata : lineWords[w];
    end else if (ctl.wordWrite && lHit) begin
      dataMem[{lIdx, lAddr[OFF_W-1:2]}] <= lWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              valid <= '0;
    else if (invAll)        valid <= '0;
    else if (ctl.lineWrite) valid[lIdx] <= 1'b1;
  end

  assign busAddr    = ctl.inFill ? {lAddr[ADDR_W-1:OFF_W], ctl.beat, 2'b00} : lAddr;
  assign busWdata   = lWdata;
  assign reqWordOff = lAddr[OFF_W-1:2];
  assign validView  = valid;
endmodule

// File: rtl/cfgscControl.sv
module cfgscControl
  import cfgsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              hit,
  input  logic              cacheable,
  input  logic              busAck,
  input  logic              invAll,
  input  logic [BEAT_W-1:0] reqWordOff,
  output ctlStrobe_t        ctl,
  output logic              busReq,
  output logic              busWrite,
  output logic              respValid,
  output logic              respFromBus
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  ctlState_t         state, nextState;
  logic [BEAT_W-1:0] beat;
  logic              lWrite;
  logic              kill;

  always_comb begin
    nextState     = state;
    ctl           = '0;
    ctl.beat      = beat;
    ctl.inFill    = (state == ST_FILL);
    busReq        = (state != ST_IDLE);
    busWrite      = (state == ST_SINGLE) && lWrite;
    respValid     = 1'b0;
    respFromBus   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite && hit) begin
            respValid = 1'b1;
          end else begin
            ctl.startMiss = 1'b1;
            nextState     = (!reqWrite && cacheable) ? ST_FILL : ST_SINGLE;
          end
        end
      end
      ST_FILL: begin
        if (busAck) begin
          ctl.fillBeat = 1'b1;
          if (beat == reqWordOff) begin
            respValid   = 1'b1;
            respFromBus = 1'b1;
          end
          if (beat == LAST_BEAT) begin
            ctl.lineWrite = !kill && !invAll;
            nextState     = ST_IDLE;
          end
        end
      end
      ST_SINGLE: begin
        if (busAck) begin
          respValid     = 1'b1;
          respFromBus   = 1'b1;
          ctl.wordWrite = lWrite;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beat   <= '0;
      lWrite <= 1'b0;
      kill   <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.startMiss) begin
        beat   <= '0;
        lWrite <= reqWrite;
        kill   <= 1'b0;
      end else if (state == ST_FILL) begin
        kill <= kill | invAll;
        if (busAck) beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgSplitCache.sv
module cfgSplitCache
  import cfgsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              invAll,
  input  logic              reqValid,
  input  logic              reqIsInstr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              respValid,
  output logic [31:0]       respData,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata
);
  ctlStrobe_t        ctl;
  logic              hit;
  logic              cacheable;
  logic [31:0]       rdWord;
  logic [BEAT_W-1:0] reqWordOff;
  logic              respFromBus;
  logic [LINES-1:0]  validView;

  cfgscControl ctrlI (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .cacheable(cacheable), .busAck(busAck), .invAll(invAll),
    .reqWordOff(reqWordOff), .ctl(ctl), .busReq(busReq), .busWrite(busWrite),
    .respValid(respValid), .respFromBus(respFromBus)
  );

  cfgscDatapath #(.ADDR_W(ADDR_W), .LINES(LINES)) dpI (
    .clk(clk), .rstN(rstN), .mode(mode), .invAll(invAll),
    .reqIsInstr(reqIsInstr), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busRdata(busRdata), .ctl(ctl), .hit(hit), .cacheable(cacheable),
    .rdWord(rdWord), .busAddr(busAddr), .busWdata(busWdata),
    .reqWordOff(reqWordOff), .validView(validView)
  );

  assign respData = respFromBus ? busRdata : rdWord;
endmodule

// File: rtl/cfgscChk.sv
module cfgscChk #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              invAll,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              respValid,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic [LINES-1:0]  validView
);
  // R1: leaving reset, nothing is cached and the bus is quiet
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busReq && validView == '0));

  // R5: a pending bus transfer holds its address and direction until acknowledged
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite)));

  // R4: an answer without bus activity is only ever a read
  a_r4_hit_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !busReq) |-> (reqValid && !reqWrite));

  // R7: a write is answered only by an acknowledged bus write
  a_r7_write_through: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && reqWrite) |-> (busReq && busAck && busWrite));

  // R9: invalidate wins over any line install in the same cycle
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> (validView == '0));
endmodule

bind cfgSplitCache cfgscChk #(.ADDR_W(ADDR_W), .LINES(LINES)) chkI (
  .clk(clk), .rstN(rstN), .invAll(invAll), .reqValid(reqValid),
  .reqWrite(reqWrite), .respValid(respValid), .busReq(busReq),
  .busWrite(busWrite), .busAddr(busAddr), .busAck(busAck),
  .validView(validView)
);

// File: tb/cfgSplitCache_tb_top.sv
module cfgSplitCache_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic        invAll = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsInstr = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        respValid;
  logic [31:0] respData;
  logic        busReq;
  logic        busWrite;
  logic [31:0] busAddr;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  cfgSplitCache dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .invAll(invAll), .reqValid(reqValid),
    .reqIsInstr(reqIsInstr), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .respValid(respValid), .respData(respData),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Backing memory of the bus
  logic [31:0] memStore [int];
  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memStore.exists(int'(a))) return memStore[int'(a)];
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h1357};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bus responder: acknowledges with irregular gaps
  always @(posedge clk) begin
    cyc++;
    #1;
    busAck   = rstN && busReq && ((cyc % 3) != 1);
    busRdata = busAck ? memRead(busAddr) : 32'hDEAD_BEEF;
  end

  // Reference model
  int          mSt = 0;
  int          mBeat = 0;
  logic [31:0] mAddr, mWdata;
  bit          mInstr, mWrite, mKill, mLHit;
  int          mTI;
  bit          mValid [int];
  logic [21:0] mTag [int];
  logic [31:0] mData [int];

  function automatic bit mCacheable(input bit instr);
    if (mode[1]) return 1'b1;
    return mode[0] ? !instr : instr;
  endfunction

  function automatic int mIdx(input logic [31:0] a, input bit instr);
    logic [6:0] r;
    r = a[10:4];
    if (mode[1]) r[6] = instr;
    return int'(r);
  endfunction

  always @(negedge clk) begin : model
    int ti;
    bit lkHit, eResp;
    logic [31:0] eAddr, eData;
    if (!rstN) begin
      mSt = 0;
      mValid.delete();
    end else begin
      ti    = mIdx(reqAddr, reqIsInstr);
      lkHit = mCacheable(reqIsInstr) && mValid.exists(ti) && mTag[ti] == reqAddr[31:10];
      case (mSt)
        0: begin
          chk("R8", "busReq idle", 32'(busReq), 32'd0);
          eResp = reqValid && !reqWrite && lkHit;
          chk("R4", "respValid lookup", 32'(respValid), 32'(eResp));
          if (eResp) chk("R4", "hit data", respData, mData[ti*4 + int'(reqAddr[3:2])]);
          if (reqValid && !eResp) begin
            mAddr = reqAddr; mWdata = reqWdata; mInstr = reqIsInstr;
            mWrite = reqWrite; mLHit = lkHit; mTI = ti; mKill = 0; mBeat = 0;
            mSt = (!reqWrite && mCacheable(reqIsInstr)) ? 1 : 2;
          end
        end
        1: begin
          eAddr = {mAddr[31:4], 2'(mBeat), 2'b00};
          chk("R5", "busReq fill", 32'(busReq), 32'd1);
          chk("R5", "busAddr fill", busAddr, eAddr);
          chk("R5", "busWrite fill", 32'(busWrite), 32'd0);
          eResp = busAck && (mBeat == int'(mAddr[3:2]));
          chk("R6", "respValid forward", 32'(respValid), 32'(eResp));
          if (eResp) chk("R6", "forward data", respData, memRead(eAddr));
          if (busAck) begin
            if (mBeat == 3) begin
              if (!mKill && !invAll) begin
                mValid[mTI] = 1'b1;
                mTag[mTI]   = mAddr[31:10];
                for (int k = 0; k < 4; k++)
                  mData[mTI*4 + k] = memRead({mAddr[31:4], 2'(k), 2'b00});
              end
              mSt = 0;
            end
            mBeat++;
          end
          mKill = mKill | invAll;
        end
        default: begin
          chk(mWrite ? "R7" : "R2", "busReq single", 32'(busReq), 32'd1);
          chk(mWrite ? "R7" : "R2", "busAddr single", busAddr, mAddr);
          chk(mWrite ? "R7" : "R2", "busWrite single", 32'(busWrite), 32'(mWrite));
          if (mWrite) chk("R7", "busWdata", busWdata, mWdata);
          chk(mWrite ? "R7" : "R2", "respValid single", 32'(respValid), 32'(busAck));
          if (busAck && !mWrite) chk("R2", "uncached data", respData, memRead(mAddr));
          if (busAck) begin
            if (mWrite) begin
              memStore[int'(mAddr)] = mWdata;
              if (mLHit) mData[mTI*4 + int'(mAddr[3:2])] = mWdata;
            end
            mSt = 0;
          end
        end
      endcase
      if (invAll) mValid.delete();
    end
  end

  // One core access; returns whether it was answered in its first cycle
  task automatic access(input logic [31:0] a, input bit instr, input bit wr,
                        input logic [31:0] wd, output bit first, output logic [31:0] rd);
    int n;
    bit got;
    reqValid = 1'b1; reqAddr = a; reqIsInstr = instr; reqWrite = wr; reqWdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      if (n == 0) first = respValid;
      rd  = respData;
      got = respValid;
      n++;
      @(posedge clk); #2;
    end while (!got && n < 200);
    reqValid = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    #2;
  endtask

  task automatic pulseInv();
    invAll = 1'b1;
    @(posedge clk); #2;
    invAll = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [31:0] a, input bit instr,
                         input bit expFirst);
    bit f;
    logic [31:0] d;
    access(a, instr, 1'b0, '0, f, d);
    chk(tag, "first-cycle hit", 32'(f), 32'(expFirst));
    chk(tag, "read data", d, memRead(a));
    settle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    bit f;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busReq after reset", 32'(busReq), 32'd0);
    chk("R1", "respValid after reset", 32'(respValid), 32'd0);
    @(posedge clk); #2;

    // data-only mode
    mode = 2'b01;
    rdCheck("R1", 32'h0000_1234, 1'b0, 1'b0);
    rdCheck("R4", 32'h0000_1234, 1'b0, 1'b1);
    rdCheck("R6", 32'h0000_1238, 1'b0, 1'b1);
    rdCheck("R2", 32'h0000_1234, 1'b1, 1'b0);
    rdCheck("R2", 32'h0000_1234, 1'b1, 1'b0);

    // write hit, then write miss
    access(32'h0000_1234, 1'b0, 1'b1, 32'hCAFE_0001, f, d); settle();
    rdCheck("R7", 32'h0000_1234, 1'b0, 1'b1);
    access(32'h0000_5000, 1'b0, 1'b1, 32'hCAFE_0002, f, d); settle();
    rdCheck("R7", 32'h0000_5000, 1'b0, 1'b0);

    // same index, different tag
    rdCheck("R3", 32'h0000_1A34, 1'b0, 1'b0);
    rdCheck("R3", 32'h0000_1234, 1'b0, 1'b0);

    // request queued behind an ongoing refill
    access(32'h0000_2270, 1'b0, 1'b0, '0, f, d);
    chk("R6", "forwarded data", d, memRead(32'h0000_2270));
    access(32'h0000_1234, 1'b0, 1'b0, '0, f, d);
    chk("R8", "wait behind refill", 32'(f), 32'd0);
    chk("R8", "data after wait", d, memRead(32'h0000_1234));
    settle();

    // invalidate while idle
    pulseInv(); settle();
    rdCheck("R9", 32'h0000_1234, 1'b0, 1'b0);

    // invalidate during a refill
    fork
      access(32'h0000_3000, 1'b0, 1'b0, '0, f, d);
      begin
        repeat (2) @(posedge clk);
        #2 invAll = 1'b1;
        @(posedge clk); #2 invAll = 1'b0;
      end
    join
    settle();
    rdCheck("R9", 32'h0000_3000, 1'b0, 1'b0);

    // invalidate together with a hit
    rdCheck("R11", 32'h0000_4000, 1'b0, 1'b0);
    invAll = 1'b1;
    fork
      access(32'h0000_4000, 1'b0, 1'b0, '0, f, d);
      begin
        @(posedge clk); #2 invAll = 1'b0;
      end
    join
    chk("R11", "hit beside invalidate", 32'(f), 32'd1);
    chk("R11", "data beside invalidate", d, memRead(32'h0000_4000));
    settle();
    rdCheck("R11", 32'h0000_4000, 1'b0, 1'b0);

    // split mode
    pulseInv();
    mode = 2'b10;
    settle();
    rdCheck("R10", 32'h0000_1234, 1'b1, 1'b0);
    rdCheck("R10", 32'h0000_1234, 1'b0, 1'b0);
    rdCheck("R10", 32'h0000_1234, 1'b1, 1'b1);
    rdCheck("R10", 32'h0000_1234, 1'b0, 1'b1);
    rdCheck("R3", 32'h0000_1634, 1'b0, 1'b0);
    rdCheck("R3", 32'h0000_1234, 1'b0, 1'b0);
    rdCheck("R10", 32'h0000_1234, 1'b1, 1'b1);

    // mixed traffic in split mode, checked by the model each cycle
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a;
      a = (i * 32'h0000_0A54 + 32'h0000_0118) & 32'h0000_0FFC;
      access(a, i[0], (i % 5) == 2, 32'h7700_0000 + i, f, d);
    end
    settle();

    // instruction-only mode
    pulseInv();
    mode = 2'b00;
    settle();
    rdCheck("R2", 32'h0000_0840, 1'b1, 1'b0);
    rdCheck("R2", 32'h0000_0840, 1'b1, 1'b1);
    rdCheck("R2", 32'h0000_0840, 1'b0, 1'b0);
    rdCheck("R2", 32'h0000_0840, 1'b0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule